// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of four oscillator sources drives the system clock: a low-power internal RC (LPRC), a fast internal RC (FRC), an external crystal oscillator (XOSC) and a PLL. Software posts a request with a one-cycle strobe. When the requested source already reports ready, the select moves to it on the next edge. When it does not, the request is held as a pending target. The switch then happens without further action on the first edge at which that source reports ready. The select output drives a glitch-free clock multiplexer outside this block. A status code, registered one cycle behind the select, lets software read back the source that is actually in use.

Hardware overrides software in two cases. A wake-up pulse from a low-power state forces the default internal source. So does a failure of the external oscillator while clock security is enabled and the oscillator is in use. It is in use when it is selected directly, or when the PLL is selected and fed from it. A forced return to the default source drops any pending request. A security fallback also raises a sticky failure flag, which software clears with a one-cycle pulse. A parameter builds a three-source variant without LPRC, in which FRC becomes the default source.

Top module: `sysclk_src_switch`

## Requirements
- R1: After reset, `sel` is the default source (0 = LPRC in the four-source build, 1 = FRC in the three-source build), `pending` and `fail_flag` are 0, and `status` holds the code of the default source.
- R2: A strobed request (`req_valid`=1) names a source with `req_src` (0 LPRC, 1 FRC, 2 XOSC, 3 PLL). If that source's `src_rdy` bit (same index) is 1 at the strobe, `sel` takes the new value on the next edge and `pending` stays 0.
- R3: A request for a source whose ready bit is 0 sets `pending` and leaves `sel` unchanged. On the first edge at which that source's ready bit is 1, `sel` takes the target and `pending` clears.
- R4: A newer request replaces a pending target. A request equal to the current `sel` clears `pending` and leaves `sel` unchanged.
- R5: `status` is 0x00 for LPRC, 0x04 for FRC, 0x08 for XOSC and 0x0C for PLL. It shows the value that `sel` had one cycle earlier.
- R6: A `wake_pulse` forces `sel` to the default source on the next edge and clears `pending`. It takes priority over a request strobed in the same cycle and leaves `fail_flag` unchanged.
- R7: When `css_en`=1 and `xosc_fail`=1, and either `sel` is XOSC or `sel` is PLL with `pll_src_xosc`=1, the next edge forces the default source, clears `pending` and sets `fail_flag`. In every other case `xosc_fail` has no effect.
- R8: `fail_flag` stays set until a `fail_clr` pulse clears it. If a new fallback occurs in the same cycle as `fail_clr`, the flag stays set.
- R9: In the three-source build (`HAS_LPRC`=0), the status codes are 0x00 for FRC, 0x04 for XOSC and 0x08 for PLL. A request for code 0 is ignored and leaves `sel` and `pending` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_rdy | input | 4 | Per-source ready flags, indexed by source code |
| req_valid | input | 1 | One-cycle strobe for a software request |
| req_src | input | 2 | Requested source code |
| css_en | input | 1 | Clock security enable |
| xosc_fail | input | 1 | External oscillator failure indication |
| pll_src_xosc | input | 1 | PLL reference is the external oscillator |
| wake_pulse | input | 1 | Wake-up from a low-power state |
| fail_clr | input | 1 | Write-one pulse that clears the failure flag |
| sel | output | 2 | Active source select |
| status | output | 8 | Readback code of the active source |
| pending | output | 1 | A request is waiting for its source to become ready |
| fail_flag | output | 1 | Sticky clock-security fallback flag |

## Verification
The hardest case to reach is a security fallback while the PLL runs from the external oscillator and a request is still pending. Reaching it takes a successful switch to the PLL, then a request for a source that is not ready, then a failure pulse with security enabled. Random stimulus seldom lines these up. Directed sequences build that chain on purpose. They also cover its near misses: the PLL fed from an internal source, security disabled, and a clear pulse in the same cycle as the fallback. Random traffic with held ready flags and rare failure and wake pulses then runs both builds against a reference model in the bench.

// File: rtl/sysclk_src_switch.sv
module sysclk_src_switch #(
  parameter bit HAS_LPRC = 1'b1,
  parameter int CODEW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       src_rdy,
  input  logic             req_valid,
  input  logic [1:0]       req_src,
  input  logic             css_en,
  input  logic             xosc_fail,
  input  logic             pll_src_xosc,
  input  logic             wake_pulse,
  input  logic             fail_clr,
  output logic [1:0]       sel,
  output logic [CODEW-1:0] status,
  output logic             pending,
  output logic             fail_flag
);
  localparam logic [1:0] DEF  = HAS_LPRC ? 2'd0 : 2'd1;
  localparam logic [1:0] XOSC = 2'd2;
  localparam logic [1:0] PLL  = 2'd3;

  function automatic logic [CODEW-1:0] code_of(input logic [1:0] s);
    logic [1:0] rel;
    rel = HAS_LPRC ? s : s - 2'd1;
    return {{(CODEW-4){1'b0}}, rel, 2'b00};
  endfunction

  logic [1:0] tgt, nxt_sel, nxt_tgt;
  logic       nxt_pend;

  wire req_ok    = req_valid && (HAS_LPRC || req_src != 2'd0);
  wire xosc_used = (sel == XOSC) || (sel == PLL && pll_src_xosc);
  wire css_trip  = css_en && xosc_fail && xosc_used;
  wire force_def = wake_pulse || css_trip;

  always_comb begin
    nxt_sel  = sel;
    nxt_tgt  = tgt;
    nxt_pend = pending;
    if (force_def) begin
      nxt_sel  = DEF;
      nxt_pend = 1'b0;
    end else if (req_ok) begin
      nxt_tgt = req_src;
      if (req_src == sel) begin
        nxt_pend = 1'b0;
      end else if (src_rdy[req_src]) begin
        nxt_sel  = req_src;
        nxt_pend = 1'b0;
      end else begin
        nxt_pend = 1'b1;
      end
    end else if (pending && src_rdy[tgt]) begin
      nxt_sel  = tgt;
      nxt_pend = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= DEF;
      tgt       <= DEF;
      pending   <= 1'b0;
      status    <= code_of(DEF);
      fail_flag <= 1'b0;
    end else begin
      sel       <= nxt_sel;
      tgt       <= nxt_tgt;
      pending   <= nxt_pend;
      status    <= code_of(sel);
      fail_flag <= css_trip || (fail_flag && !fail_clr);
    end
  end
endmodule

module sysclk_src_switch_chk #(
  parameter bit HAS_LPRC = 1'b1,
  parameter int CODEW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       src_rdy,
  input logic             req_valid,
  input logic [1:0]       req_src,
  input logic             css_en,
  input logic             xosc_fail,
  input logic             pll_src_xosc,
  input logic             wake_pulse,
  input logic             fail_clr,
  input logic [1:0]       sel,
  input logic [CODEW-1:0] status,
  input logic             pending,
  input logic             fail_flag
);
  localparam logic [1:0] DEF = HAS_LPRC ? 2'd0 : 2'd1;

  logic [1:0] sel_q;
  logic [3:0] rdy_q;
  logic       pend_q, trip_q, wake_q, flag_q, clr_q;
  logic [CODEW-1:0] exp_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= DEF;
      rdy_q  <= '0;
      pend_q <= 1'b0;
      trip_q <= 1'b0;
      wake_q <= 1'b0;
      flag_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      sel_q  <= sel;
      rdy_q  <= src_rdy;
      pend_q <= pending;
      trip_q <= css_en && xosc_fail && (sel == 2'd2 || (sel == 2'd3 && pll_src_xosc));
      wake_q <= wake_pulse;
      flag_q <= fail_flag;
      clr_q  <= fail_clr;
    end
  end

  always_comb begin
    if (HAS_LPRC) exp_code = CODEW'({sel_q, 2'b00});
    else          exp_code = CODEW'({sel_q - 2'd1, 2'b00});
  end

  assert_switch_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q && sel != DEF) |-> rdy_q[sel]);
  assert_pending_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pending) |-> sel == sel_q);
  assert_status_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status == exp_code);
  assert_wake_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (sel == DEF && !pending));
  assert_css_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |-> (sel == DEF && !pending && fail_flag));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_q) |-> fail_flag);
endmodule

bind sysclk_src_switch sysclk_src_switch_chk #(.HAS_LPRC(HAS_LPRC), .CODEW(CODEW)) u_chk (.*);

// File: tb/sim_sysclk_src_switch.sv
module sim_sysclk_src_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_rdy = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_src = '0;
  logic css_en = 1'b0, xosc_fail = 1'b0, pll_src_xosc = 1'b0;
  logic wake_pulse = 1'b0, fail_clr = 1'b0;

  logic [1:0] sel0, sel1;
  logic [7:0] st0, st1;
  logic pend0, pend1, fl0, fl1;

  always #2 clk = ~clk;

  sysclk_src_switch u0 (.clk, .rst_n, .src_rdy, .req_valid, .req_src, .css_en,
    .xosc_fail, .pll_src_xosc, .wake_pulse, .fail_clr,
    .sel(sel0), .status(st0), .pending(pend0), .fail_flag(fl0));
  sysclk_src_switch #(.HAS_LPRC(1'b0)) u1 (.clk, .rst_n, .src_rdy, .req_valid, .req_src,
    .css_en, .xosc_fail, .pll_src_xosc, .wake_pulse, .fail_clr,
    .sel(sel1), .status(st1), .pending(pend1), .fail_flag(fl1));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_sel[2], m_tgt[2];
  logic [7:0] m_st[2];
  logic       m_pend[2], m_fail[2];

  function automatic logic [1:0] dflt(input int v);
    return (v == 0) ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [7:0] code(input int v, input logic [1:0] s);
    if (v == 0) return {4'h0, s, 2'b00};
    case (s)
      2'd1: return 8'h00;
      2'd2: return 8'h04;
      default: return 8'h08;
    endcase
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_sel[v] = dflt(v); m_tgt[v] = dflt(v); m_pend[v] = 1'b0;
      m_fail[v] = 1'b0; m_st[v] = code(v, dflt(v));
    end
  endtask

  task automatic model_step();
    for (int v = 0; v < 2; v++) begin
      logic used, trip, ok;
      logic [1:0] s;
      logic p;
      logic [1:0] t;
      used = (m_sel[v] == 2'd2) || (m_sel[v] == 2'd3 && pll_src_xosc);
      trip = css_en && xosc_fail && used;
      ok = req_valid && (v == 0 || req_src != 2'd0);
      s = m_sel[v]; p = m_pend[v]; t = m_tgt[v];
      if (wake_pulse || trip) begin
        s = dflt(v); p = 1'b0;
      end else if (ok) begin
        t = req_src;
        if (req_src == m_sel[v]) p = 1'b0;
        else if (src_rdy[req_src]) begin s = req_src; p = 1'b0; end
        else p = 1'b1;
      end else if (m_pend[v] && src_rdy[m_tgt[v]]) begin
        s = m_tgt[v]; p = 1'b0;
      end
      m_st[v] = code(v, m_sel[v]);
      m_fail[v] = trip || (m_fail[v] && !fail_clr);
      m_sel[v] = s; m_pend[v] = p; m_tgt[v] = t;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " sel R2 R3"},     {6'd0, sel0}, {6'd0, m_sel[0]});
    chk({tag, " pending R3 R4"}, {7'd0, pend0}, {7'd0, m_pend[0]});
    chk({tag, " status R5"},     st0, m_st[0]);
    chk({tag, " fail_flag R8"},  {7'd0, fl0}, {7'd0, m_fail[0]});
    chk({tag, " sel3 R9"},       {6'd0, sel1}, {6'd0, m_sel[1]});
    chk({tag, " pend3 R9"},      {7'd0, pend1}, {7'd0, m_pend[1]});
    chk({tag, " status3 R9"},    st1, m_st[1]);
    chk({tag, " fail3 R9"},      {7'd0, fl1}, {7'd0, m_fail[1]});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
    req_valid = 1'b0; xosc_fail = 1'b0; wake_pulse = 1'b0; fail_clr = 1'b0;
  endtask

  task automatic req(input logic [1:0] s, input string tag);
    req_valid = 1'b1; req_src = s; step(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");
    chk("R1 reset status", st0, 8'h00);
    chk("R1 reset status3 R9", st1, 8'h00);

    // R3: request a source that is not ready, then let it become ready
    src_rdy = 4'b0011;
    req(2'd2, "R3 req not ready");
    step("R3 hold");
    step("R3 hold");
    src_rdy = 4'b0111;
    step("R3 ready switch");
    step("R5 status after switch");
    chk("R5 code XOSC", st0, 8'h08);

    // R2: ready source switches at once
    src_rdy = 4'b1111;
    req(2'd3, "R2 ready switch");
    step("R5 status PLL");
    chk("R5 code PLL", st0, 8'h0C);

    // R4: replacement and self request
    src_rdy = 4'b1000;
    req(2'd2, "R4 first pending");
    req(2'd1, "R4 replaced");
    src_rdy = 4'b1100;
    step("R4 old target ignored");
    src_rdy = 4'b1110;
    step("R4 new target switch");
    src_rdy = 4'b0010;
    req(2'd2, "R4 pending again");
    req(2'd1, "R4 self request clears");

    // R7: fallback from XOSC
    src_rdy = 4'b1111;
    req(2'd2, "R7 to XOSC");
    css_en = 1'b0; xosc_fail = 1'b1; step("R7 css off no effect");
    css_en = 1'b1; xosc_fail = 1'b1; step("R7 fallback XOSC");
    fail_clr = 1'b1; step("R8 clear");
    // R7: PLL from internal, no fallback; PLL from XOSC with pending request
    pll_src_xosc = 1'b0;
    req(2'd3, "R7 to PLL");
    xosc_fail = 1'b1; step("R7 PLL internal no effect");
    pll_src_xosc = 1'b1;
    src_rdy = 4'b1001;
    req(2'd2, "R7 pending before fail");
    xosc_fail = 1'b1; fail_clr = 1'b1; step("R7 R8 fallback wins clear");
    step("R8 sticky");

    // R6: wake overrides a same-cycle request
    src_rdy = 4'b1111;
    req(2'd2, "R6 to XOSC");
    wake_pulse = 1'b1; req_valid = 1'b1; req_src = 2'd3; step("R6 wake wins");

    // R9: request for code 0 ignored by three-source build
    req(2'd2, "R9 setup");
    req(2'd0, "R9 code 0 ignored");

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(9) == 0) src_rdy[$urandom_range(3)] = ~src_rdy[$urandom_range(3)];
      if ($urandom_range(49) == 0) css_en = ~css_en;
      if ($urandom_range(29) == 0) pll_src_xosc = ~pll_src_xosc;
      req_valid  = ($urandom_range(4) == 0);
      req_src    = 2'($urandom_range(3));
      xosc_fail  = ($urandom_range(29) == 0);
      wake_pulse = ($urandom_range(59) == 0);
      fail_clr   = ($urandom_range(19) == 0);
      step("rand");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule